// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the configuration and status registers of an SDRAM memory controller. The command sequencing and the physical DRAM interface are outside it. Software reaches every register through two device-control bus addresses. A write to the first address loads an 8-bit register pointer. An access to the second address then reads or writes the register that the pointer selects.

Each register applies its own write mask. One timer register always holds a fixed pattern of forced bits. A read-only status register follows the rising and falling edges of two configuration bits. The ECC error status register drives a level interrupt. Each bank has a configuration register, and the block gives the bank address decoder one map-enable line per bank. A bank's line is on only while the controller's global enable bit is set and that bank's own enable bit is set.

The bus strobe `ctl_en` marks a one-cycle access, and `ctl_wr` says whether it is a write. Writes take effect at the rising clock edge of the strobe cycle. Read data is combinational from the current register state while the strobe is high.

Top module: `sdcfg_regfile`

## Requirements
- R1: A write to device-control address `BASE_ADDR` loads the 8-bit register pointer from `ctl_wdata[7:0]`. A read of `BASE_ADDR` returns the pointer zero-extended to 32 bits. The pointer resets to 0.
- R2: An access to `BASE_ADDR+1` reaches the register selected by the pointer. The pointer values are: bus error status A 0x00, bus error status B 0x08, error address 0x10, configuration 0x20, status 0x24, refresh timer 0x30, power timer 0x34, bank n configuration 0x40+4n, timing 0x80, ECC configuration 0x94, ECC error status 0x98. The error-status, error-address, configuration and ECC error status registers store the written word unchanged.
- R3: Write masks apply as follows. Refresh timer keeps 0x3FF80000. Timing keeps 0x018FC01F. ECC configuration keeps 0x00F00000. Each bank configuration register keeps 0xFFDEE001.
- R4: The power timer stores (written & 0xF8000000) | 0x07C00000, and it resets to 0x07C00000.
- R5: After reset these registers read 0: both error-status registers, error address, configuration, refresh timer, timing, ECC configuration, ECC error status and all bank registers. Status reads 0x80000000, `ecc_irq` is 0 and `bank_map_en` is all zero.
- R6: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes bit 31 from 1 to 0 sets status bit 31. Any other write leaves status bit 31 unchanged.
- R7: A configuration write that takes bit 30 from 0 to 1 sets status bit 30. A write that takes bit 30 from 1 to 0 clears status bit 30. Status bits other than 31 and 30 stay 0.
- R8: A write to the status register (pointer 0x24) changes no register.
- R9: `ecc_irq` goes high in the cycle after the ECC error status register is written with a nonzero value. It goes low in the cycle after that register is written with zero.
- R10: `bank_map_en[n]` is 1 exactly when configuration bit 31 is 1 and bit 0 of bank n's configuration register is 1.
- R11: A pointer value that names no register reads 0 and ignores writes. This includes bank offsets at or above `NBANK`. Accesses to other device-control addresses return 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_en | input | 1 | Bus access strobe, one cycle per access |
| ctl_wr | input | 1 | 1 for write, 0 for read |
| ctl_addr | input | AW | Device-control bus address |
| ctl_wdata | input | DW | Write data |
| ctl_rdata | output | DW | Read data, valid while a read strobe is high |
| ecc_irq | output | 1 | Level interrupt, high while ECC error status is nonzero |
| bank_map_en | output | NBANK | Per-bank map enable to the address decoder |

## Verification
The bench uses `NBANK` = 3 and keeps the default `BASE_ADDR`. With three banks, pointer 0x4C is a bank offset that has no register behind it, so the bench can check the unimplemented-bank path against the three live banks. The bench also drives a foreign bus address to confirm that nothing outside the address pair reacts. Random writes toggle configuration bits 31 and 30 in every combination, so the edge rules on the status register and on the map enables are exercised many times.

// File: rtl/sdcfg_pkg.sv
// Package: shared offsets, write masks and reset constants for the
// indirect SDRAM configuration register file.
package sdcfg_pkg;

    localparam int REG_W = 32;
    localparam int PTR_W = 8;

    // Register pointer values (offsets seen through the data port)
    localparam logic [PTR_W-1:0] OFS_ERRSTAT_A = 8'h00;
    localparam logic [PTR_W-1:0] OFS_ERRSTAT_B = 8'h08;
    localparam logic [PTR_W-1:0] OFS_ERRADDR   = 8'h10;
    localparam logic [PTR_W-1:0] OFS_CONFIG    = 8'h20;
    localparam logic [PTR_W-1:0] OFS_STATUS    = 8'h24;
    localparam logic [PTR_W-1:0] OFS_REFRESH   = 8'h30;
    localparam logic [PTR_W-1:0] OFS_PWRTIMER  = 8'h34;
    localparam logic [PTR_W-1:0] OFS_BANK_BASE = 8'h40;
    localparam logic [PTR_W-1:0] OFS_TIMING    = 8'h80;
    localparam logic [PTR_W-1:0] OFS_ECCCONF   = 8'h94;
    localparam logic [PTR_W-1:0] OFS_ECCERR    = 8'h98;

    // Write masks
    localparam logic [REG_W-1:0] MSK_REFRESH  = 32'h3FF8_0000;
    localparam logic [REG_W-1:0] MSK_TIMING   = 32'h018F_C01F;
    localparam logic [REG_W-1:0] MSK_ECCCONF  = 32'h00F0_0000;
    localparam logic [REG_W-1:0] MSK_BANK     = 32'hFFDE_E001;
    localparam logic [REG_W-1:0] MSK_PWRTIMER = 32'hF800_0000;
    localparam logic [REG_W-1:0] FRC_PWRTIMER = 32'h07C0_0000;

    // Bit positions inside configuration / status
    localparam int BIT_ENABLE = 31;
    localparam int BIT_SELFRF = 30;

    // Reset values
    localparam logic [REG_W-1:0] RST_STATUS   = 32'h8000_0000;
    localparam logic [REG_W-1:0] RST_PWRTIMER = FRC_PWRTIMER;

endpackage

// File: rtl/sdcfg_indirect_port.sv
// Module: sdcfg_indirect_port
// Decodes the two device-control addresses of the indirect pair and holds
// the register pointer. Assumes one-cycle access strobes; a write takes
// effect at the clock edge that ends the strobe cycle.
module sdcfg_indirect_port #(
    parameter int          AW        = 10,
    parameter int          DW        = 32,
    parameter int          PW        = 8,
    parameter logic [AW-1:0] BASE_ADDR = 10'h010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic          ctl_wr,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    output logic [PW-1:0] ptr_q,
    output logic          data_we,
    output logic          data_re,
    output logic          ptr_re
);

    localparam logic [AW-1:0] DATA_ADDR = BASE_ADDR + AW'(1);

    logic hit_ptr;
    logic hit_data;

    // Address match for the two ports of the pair
    always_comb begin
        hit_ptr  = ctl_en && (ctl_addr == BASE_ADDR);
        hit_data = ctl_en && (ctl_addr == DATA_ADDR);
        data_we  = hit_data && ctl_wr;
        data_re  = hit_data && !ctl_wr;
        ptr_re   = hit_ptr && !ctl_wr;
    end

    // Pointer register: loaded from the low byte of a pointer-port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (hit_ptr && ctl_wr) begin
            ptr_q <= ctl_wdata[PW-1:0];
        end
    end

endmodule

// File: rtl/sdcfg_ctrl_status.sv
// Module: sdcfg_ctrl_status
// Holds the configuration register and the read-only status register.
// Status bits 31 and 30 change only on edges of the matching configuration
// bits carried by a configuration write; all other status bits stay zero.
module sdcfg_ctrl_status
    import sdcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic [REG_W-1:0] status_q
);

    logic en_rise, en_fall, sr_rise, sr_fall;

    // Edge detection between stored and incoming configuration bits
    always_comb begin
        en_rise = cfg_we && !cfg_q[BIT_ENABLE] &&  wdata[BIT_ENABLE];
        en_fall = cfg_we &&  cfg_q[BIT_ENABLE] && !wdata[BIT_ENABLE];
        sr_rise = cfg_we && !cfg_q[BIT_SELFRF] &&  wdata[BIT_SELFRF];
        sr_fall = cfg_we &&  cfg_q[BIT_SELFRF] && !wdata[BIT_SELFRF];
    end

    // Configuration register: stores the written word as is
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= wdata;
        end
    end

    // Status register: enable edge inverts into bit 31, self-refresh follows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RST_STATUS;
        end else begin
            if (en_rise) begin
                status_q[BIT_ENABLE] <= 1'b0;
            end else if (en_fall) begin
                status_q[BIT_ENABLE] <= 1'b1;
            end
            if (sr_rise) begin
                status_q[BIT_SELFRF] <= 1'b1;
            end else if (sr_fall) begin
                status_q[BIT_SELFRF] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcfg_bank_regs.sv
// Module: sdcfg_bank_regs
// One masked configuration register per bank, replicated by generate.
// Drives one map-enable line per bank, gated by the global enable.
// Assumes the caller has checked that bank_idx < NBANK.
module sdcfg_bank_regs
    import sdcfg_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int IW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bank_we,
    input  logic [IW-1:0]               bank_idx,
    input  logic [REG_W-1:0]            wdata,
    input  logic                        map_on,
    output logic [NBANK-1:0][REG_W-1:0] bank_q,
    output logic [NBANK-1:0]            bank_map_en
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Bank register g: masked store when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (bank_we && (bank_idx == IW'(g))) begin
                bank_q[g] <= wdata & MSK_BANK;
            end
        end

        // Map enable g: global enable and bank enable bit together
        always_comb begin
            bank_map_en[g] = map_on && bank_q[g][0];
        end
    end

endmodule

// File: rtl/sdcfg_ecc_irq.sv
// Module: sdcfg_ecc_irq
// ECC configuration and ECC error status registers, and the interrupt
// level that follows the error status. The interrupt is registered and
// updates in the same edge as the error status write.
module sdcfg_ecc_irq
    import sdcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conf_we,
    input  logic             err_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ecc_conf_q,
    output logic [REG_W-1:0] ecc_err_q,
    output logic             irq_q
);

    // ECC configuration: masked store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_conf_q <= '0;
        end else if (conf_we) begin
            ecc_conf_q <= wdata & MSK_ECCCONF;
        end
    end

    // ECC error status and interrupt level: raised on nonzero, dropped on zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_err_q <= '0;
            irq_q     <= 1'b0;
        end else if (err_we) begin
            ecc_err_q <= wdata;
            irq_q     <= (wdata != '0);
        end
    end

endmodule

// File: rtl/sdcfg_regfile.sv
// Module: sdcfg_regfile (top)
// Indirect register file of an SDRAM controller. A pointer register at
// BASE_ADDR selects which internal register BASE_ADDR+1 reaches. Holds the
// error, timer and timing registers locally; configuration/status, bank and
// ECC registers live in submodules. Read data is combinational.
// Assumes NBANK in 1..4 and DW equal to the package register width.
module sdcfg_regfile
    import sdcfg_pkg::*;
#(
    parameter int            AW        = 10,
    parameter int            DW        = 32,
    parameter int            NBANK     = 4,
    parameter logic [AW-1:0] BASE_ADDR = 10'h010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             ctl_wr,
    input  logic [AW-1:0]    ctl_addr,
    input  logic [DW-1:0]    ctl_wdata,
    output logic [DW-1:0]    ctl_rdata,
    output logic             ecc_irq,
    output logic [NBANK-1:0] bank_map_en
);

    localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic             data_we, data_re, ptr_re;

    logic [REG_W-1:0] errstat_a_q, errstat_b_q, erraddr_q;
    logic [REG_W-1:0] refresh_q, pmit_q, timing_q;
    logic [REG_W-1:0] cfg_q, status_q;
    logic [REG_W-1:0] ecc_conf_q, ecc_err_q;
    logic [NBANK-1:0][REG_W-1:0] bank_q;

    logic             bank_hit;
    logic [IW-1:0]    bank_idx;
    logic             we_cfg, we_bank, we_eccc, we_ecce;

    sdcfg_indirect_port #(
        .AW(AW), .DW(DW), .PW(PTR_W), .BASE_ADDR(BASE_ADDR)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .ctl_en(ctl_en), .ctl_wr(ctl_wr),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ptr_q(ptr_q), .data_we(data_we), .data_re(data_re), .ptr_re(ptr_re)
    );

    // Bank offset decode: 0x40 + 4*n, n below NBANK
    always_comb begin
        bank_idx = IW'(ptr_q[3:2]);
        bank_hit = (ptr_q[7:4] == OFS_BANK_BASE[7:4]) && (ptr_q[1:0] == 2'b00)
                   && (32'(ptr_q[3:2]) < NBANK);
    end

    // Write strobes for registers held in submodules
    always_comb begin
        we_cfg  = data_we && (ptr_q == OFS_CONFIG);
        we_bank = data_we && bank_hit;
        we_eccc = data_we && (ptr_q == OFS_ECCCONF);
        we_ecce = data_we && (ptr_q == OFS_ECCERR);
    end

    sdcfg_ctrl_status u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(we_cfg), .wdata(ctl_wdata),
        .cfg_q(cfg_q), .status_q(status_q)
    );

    sdcfg_bank_regs #(
        .NBANK(NBANK), .IW(IW)
    ) u_banks (
        .clk(clk), .rst_n(rst_n),
        .bank_we(we_bank), .bank_idx(bank_idx), .wdata(ctl_wdata),
        .map_on(cfg_q[BIT_ENABLE]),
        .bank_q(bank_q), .bank_map_en(bank_map_en)
    );

    sdcfg_ecc_irq u_ecc (
        .clk(clk), .rst_n(rst_n),
        .conf_we(we_eccc), .err_we(we_ecce), .wdata(ctl_wdata),
        .ecc_conf_q(ecc_conf_q), .ecc_err_q(ecc_err_q), .irq_q(ecc_irq)
    );

    // Local registers: error capture, timers and timing, each with its mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            errstat_a_q <= '0;
            errstat_b_q <= '0;
            erraddr_q   <= '0;
            refresh_q   <= '0;
            pmit_q      <= RST_PWRTIMER;
            timing_q    <= '0;
        end else if (data_we) begin
            case (ptr_q)
                OFS_ERRSTAT_A: errstat_a_q <= ctl_wdata;
                OFS_ERRSTAT_B: errstat_b_q <= ctl_wdata;
                OFS_ERRADDR:   erraddr_q   <= ctl_wdata;
                OFS_REFRESH:   refresh_q   <= ctl_wdata & MSK_REFRESH;
                OFS_PWRTIMER:  pmit_q      <= (ctl_wdata & MSK_PWRTIMER) | FRC_PWRTIMER;
                OFS_TIMING:    timing_q    <= ctl_wdata & MSK_TIMING;
                default: ;
            endcase
        end
    end

    // Read mux: pointer port, selected register, or zero
    always_comb begin
        ctl_rdata = '0;
        if (ptr_re) begin
            ctl_rdata = DW'(ptr_q);
        end else if (data_re) begin
            if (bank_hit) begin
                ctl_rdata = bank_q[bank_idx];
            end else begin
                case (ptr_q)
                    OFS_ERRSTAT_A: ctl_rdata = errstat_a_q;
                    OFS_ERRSTAT_B: ctl_rdata = errstat_b_q;
                    OFS_ERRADDR:   ctl_rdata = erraddr_q;
                    OFS_CONFIG:    ctl_rdata = cfg_q;
                    OFS_STATUS:    ctl_rdata = status_q;
                    OFS_REFRESH:   ctl_rdata = refresh_q;
                    OFS_PWRTIMER:  ctl_rdata = pmit_q;
                    OFS_TIMING:    ctl_rdata = timing_q;
                    OFS_ECCCONF:   ctl_rdata = ecc_conf_q;
                    OFS_ECCERR:    ctl_rdata = ecc_err_q;
                    default:       ctl_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdcfg_regfile_chk.sv
// Module: sdcfg_regfile_chk
// Property checker bound to sdcfg_regfile. Observes the bus ports and the
// pointer, configuration, status and power timer state.
module sdcfg_regfile_chk #(
    parameter int            AW        = 10,
    parameter int            DW        = 32,
    parameter int            NBANK     = 4,
    parameter logic [AW-1:0] BASE_ADDR = 10'h010
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_en,
    input logic             ctl_wr,
    input logic [AW-1:0]    ctl_addr,
    input logic [DW-1:0]    ctl_wdata,
    input logic             ecc_irq,
    input logic [NBANK-1:0] bank_map_en,
    input logic [7:0]       ptr_q,
    input logic [31:0]      cfg_q,
    input logic [31:0]      status_q,
    input logic [31:0]      pmit_q
);

    logic wr_ptr, wr_data;

    // Bus write classification for the two ports
    always_comb begin
        wr_ptr  = ctl_en && ctl_wr && (ctl_addr == BASE_ADDR);
        wr_data = ctl_en && ctl_wr && (ctl_addr == BASE_ADDR + AW'(1));
    end

    a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> (ptr_q == $past(ctl_wdata[7:0])));

    a_r4_pmit_forced: assert property (@(posedge clk) disable iff (!rst_n)
        pmit_q[26:22] == 5'h1F);

    a_r6_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h20 && ctl_wdata[31] && !cfg_q[31]) |=> !status_q[31]);

    a_r6_disable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h20 && !ctl_wdata[31] && cfg_q[31]) |=> status_q[31]);

    a_r7_selfrf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h20 && ctl_wdata[30] && !cfg_q[30]) |=> status_q[30]);

    a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h24) |=> $stable(status_q));

    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h98 && ctl_wdata != '0) |=> ecc_irq);

    a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ptr_q == 8'h98 && ctl_wdata == '0) |=> !ecc_irq);

    a_r10_map_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[31] |-> (bank_map_en == '0));

endmodule

bind sdcfg_regfile sdcfg_regfile_chk #(
    .AW(AW), .DW(DW), .NBANK(NBANK), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctl_en(ctl_en), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ecc_irq(ecc_irq), .bank_map_en(bank_map_en),
    .ptr_q(ptr_q), .cfg_q(cfg_q), .status_q(status_q), .pmit_q(pmit_q)
);

// File: tb/test_sdcfg_regfile.sv
`timescale 1ns/1ps
// Bench for sdcfg_regfile: directed corner cases, then seeded random
// register traffic checked against a model built from the requirements.
module test_sdcfg_regfile;

    localparam int            AW   = 10;
    localparam int            DW   = 32;
    localparam int            NB   = 3;
    localparam logic [AW-1:0] BASE = 10'h010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_en = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [AW-1:0] ctl_addr = '0;
    logic [DW-1:0] ctl_wdata = '0;
    logic [DW-1:0] ctl_rdata;
    logic          ecc_irq;
    logic [NB-1:0] bank_map_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdcfg_regfile #(.AW(AW), .DW(DW), .NBANK(NB), .BASE_ADDR(BASE)) i_sdcfg_regfile (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_wr(ctl_wr),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .ecc_irq(ecc_irq), .bank_map_en(bank_map_en)
    );

    // Model state
    logic [31:0] m_ea, m_eb, m_addr, m_cfg, m_st, m_rtr, m_pm, m_tr, m_ec, m_ee;
    logic [31:0] m_bank [4];
    logic [7:0]  m_ptr;

    task automatic model_reset();
        m_ea = 0; m_eb = 0; m_addr = 0; m_cfg = 0; m_st = 32'h8000_0000;
        m_rtr = 0; m_pm = 32'h07C0_0000; m_tr = 0; m_ec = 0; m_ee = 0; m_ptr = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    task automatic model_write(input logic [7:0] off, input logic [31:0] v);
        case (off)
            8'h00: m_ea = v;
            8'h08: m_eb = v;
            8'h10: m_addr = v;
            8'h20: begin
                if (!m_cfg[31] && v[31]) m_st[31] = 1'b0;
                else if (m_cfg[31] && !v[31]) m_st[31] = 1'b1;
                if (!m_cfg[30] && v[30]) m_st[30] = 1'b1;
                else if (m_cfg[30] && !v[30]) m_st[30] = 1'b0;
                m_cfg = v;
            end
            8'h30: m_rtr = v & 32'h3FF8_0000;
            8'h34: m_pm = (v & 32'hF800_0000) | 32'h07C0_0000;
            8'h40, 8'h44, 8'h48, 8'h4C:
                if (int'(off[3:2]) < NB) m_bank[off[3:2]] = v & 32'hFFDE_E001;
            8'h80: m_tr = v & 32'h018F_C01F;
            8'h94: m_ec = v & 32'h00F0_0000;
            8'h98: m_ee = v;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] off);
        case (off)
            8'h00: return m_ea;
            8'h08: return m_eb;
            8'h10: return m_addr;
            8'h20: return m_cfg;
            8'h24: return m_st;
            8'h30: return m_rtr;
            8'h34: return m_pm;
            8'h40, 8'h44, 8'h48, 8'h4C:
                return (int'(off[3:2]) < NB) ? m_bank[off[3:2]] : 32'h0;
            8'h80: return m_tr;
            8'h94: return m_ec;
            8'h98: return m_ee;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [NB-1:0] model_map();
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) r[i] = m_cfg[31] && m_bank[i][0];
        return r;
    endfunction

    function automatic logic [7:0] pick_off(input int n);
        case (n % 18)
            0: return 8'h00;  1: return 8'h08;  2: return 8'h10;  3: return 8'h20;
            4: return 8'h24;  5: return 8'h30;  6: return 8'h34;  7: return 8'h40;
            8: return 8'h44;  9: return 8'h48;  10: return 8'h4C; 11: return 8'h80;
            12: return 8'h94; 13: return 8'h98; 14: return 8'h20; 15: return 8'h04;
            16: return 8'hFC; default: return 8'h98;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        ctl_en = 1'b1; ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_en = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        ctl_en = 1'b1; ctl_wr = 1'b0; ctl_addr = a;
        #1 d = ctl_rdata;
        ctl_en = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] off, input logic [31:0] v);
        bus_write(BASE, {24'h0, off});
        m_ptr = off;
        bus_write(BASE + 10'd1, v);
        model_write(off, v);
    endtask

    task automatic reg_check(input string tag, input logic [7:0] off);
        logic [31:0] d;
        bus_write(BASE, {24'h0, off});
        m_ptr = off;
        bus_read(BASE + 10'd1, d);
        chk(tag, d, model_read(off));
    endtask

    task automatic out_check(input string tag);
        @(negedge clk);
        #1;
        chk({tag, " irq"}, {31'h0, ecc_irq}, {31'h0, (m_ee != 0)});
        chk({tag, " map"}, {{(32-NB){1'b0}}, bank_map_en}, {{(32-NB){1'b0}}, model_map()});
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h00C0_FFEE));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R5: reset values
        for (int i = 0; i < 17; i++) reg_check("R5 reset", pick_off(i));
        out_check("R5");

        // R1: pointer readback
        bus_write(BASE, 32'hFFFF_FFA5);
        bus_read(BASE, d);
        chk("R1 pointer", d, 32'h0000_00A5);

        // R2: plain registers
        reg_write(8'h10, 32'hDEAD_BEEF); reg_check("R2 erraddr", 8'h10);
        reg_write(8'h08, 32'h1234_5678); reg_check("R2 errstat", 8'h08);

        // R4: power timer
        reg_write(8'h34, 32'hFFFF_FFFF); reg_check("R4 pmit ones", 8'h34);
        reg_write(8'h34, 32'h0);         reg_check("R4 pmit zero", 8'h34);

        // R3: masks
        reg_write(8'h30, 32'hFFFF_FFFF); reg_check("R3 refresh", 8'h30);
        reg_write(8'h80, 32'hFFFF_FFFF); reg_check("R3 timing", 8'h80);
        reg_write(8'h94, 32'hFFFF_FFFF); reg_check("R3 ecc conf", 8'h94);
        reg_write(8'h44, 32'hFFFF_FFFF); reg_check("R3 bank1", 8'h44);

        // R6 R10: enable edge
        reg_write(8'h40, 32'h0000_0001);
        out_check("R10 off");
        reg_write(8'h20, 32'h8000_0000);
        reg_check("R6 rise", 8'h24);
        out_check("R10 on");
        // R7: self-refresh edges
        reg_write(8'h20, 32'hC000_0000); reg_check("R7 rise", 8'h24);
        reg_write(8'h20, 32'h0000_0000); reg_check("R7 R6 fall", 8'h24);
        out_check("R10 off again");

        // R8: status write ignored
        reg_write(8'h24, 32'h0000_0000); reg_check("R8 status", 8'h24);
        reg_check("R8 config", 8'h20);

        // R9: interrupt
        reg_write(8'h98, 32'h0000_0010); out_check("R9 raise");
        reg_write(8'h98, 32'h0000_0020); out_check("R9 hold");
        reg_write(8'h98, 32'h0);         out_check("R9 drop");

        // R11: unimplemented offsets and foreign addresses
        reg_write(8'h4C, 32'hFFFF_FFFF); reg_check("R11 bank3", 8'h4C);
        reg_write(8'h04, 32'hFFFF_FFFF); reg_check("R11 hole", 8'h04);
        bus_write(BASE, 32'h0000_0010);
        m_ptr = 8'h10;
        bus_write(10'h055, 32'h0000_0020);
        bus_read(10'h055, d);
        chk("R11 foreign read", d, 32'h0);
        bus_read(BASE, d);
        chk("R11 foreign write", d, 32'h0000_0010);

        // Random traffic (R2 R3 R4 R6 R7 R9 R10)
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  off;
            logic [31:0] v;
            off = pick_off(int'($urandom % 18));
            v   = $urandom;
            if (off == 8'h98 && ($urandom % 2) == 0) v = 0;
            reg_write(off, v);
            reg_check("R2 random", pick_off(int'($urandom % 18)));
            if (it % 8 == 0) reg_check("R6 R7 random status", 8'h24);
            out_check("R9 R10 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule